// File: doc/BRIEF.md
# Overcurrent window trip latch

This block guards a three-phase inverter against overcurrent. Each phase-current channel delivers a 12-bit offset-binary sample in which midscale stands for zero current. The block checks every sample against a window of plus and minus one programmable limit around midscale. Each side of the window passes through a sampled majority filter, so that a short disturbance is rejected. The filtered trips of the enabled channels are combined with one active-low external trip pin per PWM channel.

Any trip event forces both outputs of the affected PWM channel high in the cycle it occurs. The trip is then recorded in a sticky per-channel flag, and one cycle later a global shutdown latch forces every PWM channel and sets every channel's flag. The motor run-enable drops as soon as any flag is set. Only a clear strobe releases the flags, the shutdown latch and the per-side comparator status latches. A cause that is still present re-trips on the following cycle.

Top module: `ocp_trip_latch`

## Requirements
- R1: The high limit is 2048 + `ilim` and the low limit is 2048 − `ilim` (for W = 12). A sample strictly above the high limit is a high-side violation, a sample strictly below the low limit is a low-side violation, and a sample equal to either limit is neither.
- R2: Each side of each channel has its own filter. The filter takes the raw violation into a WIN-bit window once every PRE clocks. Its output rises when at least THR of the window bits are ones and falls when at least THR are zeros. A violation lasting no more than PRE clocks never causes a trip, and with PRE = 2, WIN = 3 and THR = 2 a steady violation forces the outputs between 3 and 4 clocks after it appears.
- R3: A channel whose bit in `ch_en` is 0 causes no trip, but its status latches still record its filtered violations.
- R4: `hi_latch[c]` and `lo_latch[c]` set when the filtered high or low violation of channel c is present, and they hold until `clr`.
- R5: A low level on `ext_trip_n[p]` is a trip event for PWM channel p only. A high level has no effect.
- R6: A trip event forces `pwm_a_out[p]` and `pwm_b_out[p]` to 1 in the same cycle, with no register in the path. A filtered comparator trip is an event for all PWM channels.
- R7: One cycle after any trip flag is set, every PWM channel is forced high. One cycle after that, every bit of `trip_flag` is set.
- R8: `run_en` is 0 from the cycle after a trip event until a clear, and it stays low while any flag or the shutdown latch is set.
- R9: A cycle with `clr` high clears every trip flag, the shutdown latch and all comparator status latches. If a trip cause is still active, the flags set again one cycle later.
- R10: With no trip event, flag or shutdown, `pwm_a_out` and `pwm_b_out` equal `pwm_a_in` and `pwm_b_in` bit for bit.
- R11: After reset all flags and latches are 0, `run_en` is 1 and the outputs follow the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clear strobe for flags, shutdown and status latches |
| ch_en | input | NCH | Per-channel trip enable |
| samp | input | NCH*W | Offset-binary current samples, channel c at bits c*W +: W |
| ilim | input | W-1 | Limit in counts on each side of midscale |
| ext_trip_n | input | NPWM | Active-low external trip, one per PWM channel |
| pwm_a_in | input | NPWM | PWM A outputs from the generator |
| pwm_b_in | input | NPWM | PWM B outputs from the generator |
| pwm_a_out | output | NPWM | Gated PWM A, forced high on trip |
| pwm_b_out | output | NPWM | Gated PWM B, forced high on trip |
| trip_flag | output | NPWM | Sticky per-channel trip flags |
| run_en | output | 1 | Motor run-enable, low while tripped |
| hi_latch | output | NCH | Sticky filtered high-side status per channel |
| lo_latch | output | NCH | Sticky filtered low-side status per channel |

## Verification
The properties assume that `ext_trip_n`, `samp` and `clr` are synchronous to `clk`, so the combinational force path sees settled levels at each edge. The bench therefore changes every input only at the falling edge. The properties also assume that `clr` is a strobe that the filters do not depend on. The bench pulses it for single cycles, and it holds a violation well past the filter settling time before it checks anything, except in the tests that probe the filter window itself.

// File: rtl/ocp_trip_latch.sv
module ocp_trip_latch #(
  parameter int W    = 12,
  parameter int NCH  = 2,
  parameter int NPWM = 3,
  parameter int PRE  = 20,
  parameter int WIN  = 8,
  parameter int THR  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [NCH-1:0]   ch_en,
  input  logic [NCH*W-1:0] samp,
  input  logic [W-2:0]     ilim,
  input  logic [NPWM-1:0]  ext_trip_n,
  input  logic [NPWM-1:0]  pwm_a_in,
  input  logic [NPWM-1:0]  pwm_b_in,
  output logic [NPWM-1:0]  pwm_a_out,
  output logic [NPWM-1:0]  pwm_b_out,
  output logic [NPWM-1:0]  trip_flag,
  output logic             run_en,
  output logic [NCH-1:0]   hi_latch,
  output logic [NCH-1:0]   lo_latch
);
  localparam int PW  = (PRE > 1) ? $clog2(PRE) : 1;
  localparam int MID = 1 << (W - 1);
  localparam int NF  = 2 * NCH;

  logic [PW-1:0]   pre_cnt;
  logic            strobe;
  logic [W-1:0]    lim_hi, lim_lo;
  logic [NF-1:0]   raw, filt, lat, fen;
  logic            cmp_trip, shut;
  logic [NPWM-1:0] evt, force_hi;

  assign strobe = (pre_cnt == PW'(PRE - 1));
  assign lim_hi = W'(MID) + {1'b0, ilim};
  assign lim_lo = W'(MID) - {1'b0, ilim};

  always_ff @(posedge clk) begin
    if (!rst_n)      pre_cnt <= '0;
    else if (strobe) pre_cnt <= '0;
    else             pre_cnt <= pre_cnt + 1'b1;
  end

  // even filter index = high side, odd = low side (inverted compare)
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [W-1:0] s;
    assign s          = samp[c*W +: W];
    assign raw[2*c]   = (s > lim_hi);
    assign raw[2*c+1] = (s < lim_lo);
    assign fen[2*c]   = ch_en[c];
    assign fen[2*c+1] = ch_en[c];
    assign hi_latch[c] = lat[2*c];
    assign lo_latch[c] = lat[2*c+1];
  end

  for (genvar f = 0; f < NF; f++) begin : g_filt
    logic [WIN-1:0] win, nwin;
    int             ones;
    assign nwin = {win[WIN-2:0], raw[f]};
    always_comb ones = $countones(nwin);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win     <= '0;
        filt[f] <= 1'b0;
      end else if (strobe) begin
        win <= nwin;
        if (ones >= THR)            filt[f] <= 1'b1;
        else if (WIN - ones >= THR) filt[f] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || clr) lat[f] <= 1'b0;
      else if (filt[f])  lat[f] <= 1'b1;
    end
  end

  assign cmp_trip = |(filt & fen);
  assign evt      = {NPWM{cmp_trip}} | ~ext_trip_n;
  assign force_hi = evt | trip_flag | {NPWM{shut}};

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      trip_flag <= '0;
      shut      <= 1'b0;
    end else begin
      trip_flag <= trip_flag | evt | {NPWM{shut}};
      shut      <= shut | (|trip_flag);
    end
  end

  assign pwm_a_out = pwm_a_in | force_hi;
  assign pwm_b_out = pwm_b_in | force_hi;
  assign run_en    = ~(shut | (|trip_flag));
endmodule

module ocp_trip_latch_chk #(
  parameter int NCH  = 2,
  parameter int NPWM = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clr,
  input logic [NPWM-1:0] ext_trip_n,
  input logic [NPWM-1:0] pwm_a_out,
  input logic [NPWM-1:0] pwm_b_out,
  input logic [NPWM-1:0] trip_flag,
  input logic            run_en,
  input logic [NCH-1:0]  hi_latch,
  input logic [NCH-1:0]  lo_latch
);
  assert_flag_forces_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((trip_flag & ~(pwm_a_out & pwm_b_out)) == '0));

  assert_ext_forces_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~ext_trip_n & ~(pwm_a_out & pwm_b_out)) == '0));

  assert_spread_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_flag != '0 && !clr) |=> (&pwm_a_out && &pwm_b_out));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_flag != '0 && !clr) |=> ((trip_flag & $past(trip_flag)) == $past(trip_flag)));

  assert_run_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_flag != '0) |-> !run_en);

  assert_run_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !clr) |=> !run_en);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (trip_flag == '0 && hi_latch == '0 && lo_latch == '0));

  assert_latch_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_latch != '0 && !clr) |=> ((hi_latch & $past(hi_latch)) == $past(hi_latch)));
endmodule

bind ocp_trip_latch ocp_trip_latch_chk #(.NCH(NCH), .NPWM(NPWM)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .ext_trip_n(ext_trip_n),
  .pwm_a_out(pwm_a_out), .pwm_b_out(pwm_b_out), .trip_flag(trip_flag),
  .run_en(run_en), .hi_latch(hi_latch), .lo_latch(lo_latch)
);

// File: tb/ocp_trip_latch_tb.sv
module ocp_trip_latch_tb;
  localparam int W = 12, NCH = 2, NPWM = 3, PRE = 2, WIN = 3, THR = 2;

  logic clk = 0, rst_n = 0, clr = 0;
  logic [NCH-1:0]   ch_en = '1;
  logic [NCH*W-1:0] samp;
  logic [W-2:0]     ilim = 11'd1365;
  logic [NPWM-1:0]  ext_trip_n = '1, pwm_a_in = '0, pwm_b_in = '0;
  logic [NPWM-1:0]  pwm_a_out, pwm_b_out, trip_flag;
  logic             run_en;
  logic [NCH-1:0]   hi_latch, lo_latch;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ocp_trip_latch #(.W(W), .NCH(NCH), .NPWM(NPWM), .PRE(PRE), .WIN(WIN), .THR(THR)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ch_en(ch_en), .samp(samp), .ilim(ilim),
    .ext_trip_n(ext_trip_n), .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in),
    .pwm_a_out(pwm_a_out), .pwm_b_out(pwm_b_out), .trip_flag(trip_flag),
    .run_en(run_en), .hi_latch(hi_latch), .lo_latch(lo_latch));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_samp(input int c, input int v);
    samp[c*W +: W] = W'(v);
  endtask

  task automatic pulse_clr();
    clr = 1; step(1); clr = 0;
  endtask

  task automatic settle_clear();
    set_samp(0, 2048); set_samp(1, 2048); ext_trip_n = '1;
    step(8); pulse_clr(); step(1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    samp = {NCH{12'd2048}};
    step(3); rst_n = 1; step(1);

    // R11 reset state
    check("R11 flags", trip_flag, 0);
    check("R11 run_en", run_en, 1);
    check("R11 latches", {hi_latch, lo_latch}, 0);
    check("R11 passthrough", pwm_a_out, 0);

    // R10 passthrough, all input patterns
    for (int v = 0; v < 64; v++) begin
      pwm_a_in = v[2:0]; pwm_b_in = v[5:3]; step(1);
      check("R10 pwm_a", pwm_a_out, v[2:0]);
      check("R10 pwm_b", pwm_b_out, v[5:3]);
    end
    pwm_a_in = '0; pwm_b_in = '0;

    // R1 limit sweep around both window edges
    for (int li = 0; li < 4; li++) begin
      int lv, hi, lo;
      lv = (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 1365 : 2047;
      ilim = 11'(lv); hi = 2048 + lv; lo = 2048 - lv;
      for (int k = 0; k < 9; k++) begin
        int s;
        bit eh, el;
        s = (k < 3) ? hi - 1 + k : (k < 6) ? lo - 4 + k : (k == 6) ? 0 : (k == 7) ? 4095 : 2048;
        if (s < 0 || s > 4095) continue;
        eh = (s > hi); el = (s < lo);
        set_samp(0, s); step(6);
        check("R1 high latch", hi_latch[0], eh);
        check("R1 low latch", lo_latch[0], el);
        check("R1 R6 forced outputs", pwm_a_out, (eh | el) ? 7 : 0);
        check("R7 all flags", trip_flag, (eh | el) ? 7 : 0);
        settle_clear();
        check("R9 cleared", {trip_flag, run_en}, 1);
      end
    end
    ilim = 11'd1365;

    // R2 filter timing bounds for a steady violation
    set_samp(0, 3500); step(2);
    check("R2 not yet tripped", pwm_b_out, 0);
    step(2);
    check("R2 tripped by 4 clocks", pwm_b_out, 7);
    settle_clear();

    // R2 a violation of PRE clocks is rejected
    set_samp(0, 100); step(PRE); set_samp(0, 2048); step(10);
    check("R2 glitch no trip", trip_flag, 0);
    check("R2 glitch no latch", lo_latch, 0);

    // R3 disabled channel: no trip, latch still records
    ch_en = 2'b01; set_samp(1, 4095); step(8);
    check("R3 no flags", trip_flag, 0);
    check("R3 outputs pass", pwm_a_out, 0);
    check("R3 latch records", hi_latch, 2'b10);
    check("R4 latch holds", hi_latch[1], 1);
    settle_clear();
    check("R4 latch cleared", hi_latch, 0);
    ch_en = '1;

    // R5/R6/R7/R8 external pin on PWM channel 1
    pwm_a_in = 3'b000; pwm_b_in = 3'b000;
    ext_trip_n = 3'b101; #1;
    check("R6 same cycle A", pwm_a_out, 3'b010);
    check("R6 same cycle B", pwm_b_out, 3'b010);
    step(1); ext_trip_n = '1;
    check("R5 own flag only", trip_flag, 3'b010);
    check("R8 run_en low", run_en, 0);
    check("R7 not spread yet", pwm_a_out, 3'b010);
    step(1);
    check("R7 all forced", {pwm_a_out, pwm_b_out}, 6'h3f);
    step(1);
    check("R7 all flags", trip_flag, 7);
    step(5);
    check("R8 run_en held", run_en, 0);
    pulse_clr();
    check("R9 clear flags", trip_flag, 0);
    check("R9 clear run_en", run_en, 1);
    check("R5 high pin no effect", pwm_a_out, 0);

    // R9 re-latch while cause still active
    set_samp(0, 4000); step(6);
    pulse_clr();
    check("R9 cleared under cause", trip_flag, 0);
    step(1);
    check("R9 re-latched", trip_flag, 7);
    settle_clear();
    check("R9 final clear", {trip_flag, hi_latch, lo_latch}, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule